// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block is a synchronous front end for an external asynchronous static RAM of 131072 words by 16 bits. A host hands it one request at a time: a word address, write data, a two-bit byte mask and a read/write flag. The controller turns each request into a sequence of active-low memory strobes: chip select, write strobe, output enable and one enable per byte lane. It also decides, cycle by cycle, whether the controller drives the shared data bus.

All memory timing is set by module parameters given in nanoseconds together with the clock period. Each time is rounded up to a whole number of cycles. A read keeps its strobes low for the read-cycle count and captures the bus on the last of those cycles. A write keeps its strobes low for the write-cycle count. It then raises the write strobe while the controller still drives the data for one more cycle. After every read the controller waits for the output-disable time before it accepts new work, so the memory has let go of the bus before the controller drives it.

Byte lanes not selected in the mask see their enable held high. On a read, an unselected lane returns zero. A request with an empty mask touches no strobe and completes at once.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset, and whenever `ready` is high, chip select, write strobe, output enable and both lane enables are high and `mem_dq_oe` is low.
- R2: A read drives chip select and output enable low with the write strobe high for exactly ceil(T_RC_NS/CLK_NS) consecutive cycles. Lane enable bit 0 (bits 7:0) is low when mask bit 0 is set, and lane enable bit 1 (bits 15:8) is low when mask bit 1 is set.
- R3: On the cycle after a read's last strobe cycle, `done` and `rd_valid` are high for one cycle. `rd_data` then holds the bus value sampled on that last strobe cycle, with unselected lanes forced to zero.
- R4: A write drives chip select and the write strobe low with output enable high for exactly ceil(T_WC_NS/CLK_NS) cycles. Lane enables follow the mask as in R2, and `mem_dq_out` carries the request's write data with `mem_dq_oe` high.
- R5: A write ends with one cycle in which all strobes are high while `mem_dq_oe` stays high with the same data. The bus is released on the next cycle, and `done` pulses for that cycle.
- R6: `mem_dq_oe` is never high in a cycle where output enable is low.
- R7: After a read, `ready` stays low for ceil(T_OEHZ_NS/CLK_NS) cycles, counting from the `rd_valid` cycle, and the bus is not driven during that time.
- R8: A request with mask 00 leaves every strobe high, pulses `done` on the next cycle, and never raises `rd_valid`.
- R9: `req_valid` while `ready` is low is ignored: strobes, outputs and memory contents are unaffected.
- R10: `mem_addr` holds the request's address, unchanged, for every cycle of an access in which chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte mask, bit i selects bits 8i+7:8i |
| ready | output | 1 | Controller can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle read-data pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane enables, active low |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | DATA_W | Data from memory pads |

## Verification
The bench builds the block with its default values: a 5 ns clock with 55 ns read and write cycles and a 20 ns output-disable time. This gives 11 read cycles, 11 write cycles and a 4-cycle recovery window. These counts are short enough that every strobe cycle of every access is compared against a queue of expected cycles. The bench memory returns a junk pattern on disabled lanes, which makes the zeroing of unselected lanes visible. The highest address and requests held through the recovery window are also covered.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_WEND  = 2'd3
  } ctl_state_t;

  // Whole cycles covering a time in ns, never below one.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES = 2
) (
  input  logic                 active,
  input  logic [LANES-1:0]     mask,
  input  logic [8*LANES-1:0]   raw,
  output logic [LANES-1:0]     lane_n,
  output logic [8*LANES-1:0]   masked
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i]       = ~(active & mask[i]);
    assign masked[8*i +: 8] = mask[i] ? raw[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 5,
  parameter int T_RC_NS   = 55,
  parameter int T_WC_NS   = 55,
  parameter int T_OEHZ_NS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                ready,
  output logic                done,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);
  localparam int LANES    = DATA_W / 8;
  localparam int RD_CYC   = ns_to_cycles(T_RC_NS, CLK_NS);
  localparam int WR_CYC   = ns_to_cycles(T_WC_NS, CLK_NS);
  localparam int TURN_CYC = ns_to_cycles(T_OEHZ_NS, CLK_NS);
  localparam int CNT_W    = $clog2(max3(RD_CYC, WR_CYC, TURN_CYC) + 1);

  ctl_state_t           st_q, st_d;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [LANES-1:0]     mask_q;
  logic                 done_q, rvalid_q;
  logic [DATA_W-1:0]    rdata_q;

  // Named events, also observed by the checker.
  logic accept, empty_req, rd_end, wr_end, strobing;
  logic acc_zero, turn_zero;
  logic [CNT_W-1:0] acc_len;
  logic [DATA_W-1:0] rd_masked;
  logic [LANES-1:0]  lane_n;

  assign ready     = (st_q == ST_IDLE) && turn_zero;
  assign accept    = ready && req_valid;
  assign empty_req = accept && (req_mask == '0);
  assign rd_end    = (st_q == ST_READ)  && acc_zero;
  assign wr_end    = (st_q == ST_WRITE) && acc_zero;
  assign strobing  = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign acc_len   = req_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);

  sram_cycle_timer #(.W(CNT_W)) u_acc_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(acc_len), .zero(acc_zero)
  );

  sram_cycle_timer #(.W(CNT_W)) u_turn_timer (
    .clk(clk), .rst_n(rst_n), .load(rd_end), .load_val(CNT_W'(TURN_CYC)), .zero(turn_zero)
  );

  sram_lane_map #(.LANES(LANES)) u_lanes (
    .active(strobing), .mask(mask_q), .raw(mem_dq_in), .lane_n(lane_n), .masked(rd_masked)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept && !empty_req) st_d = req_write ? ST_WRITE : ST_READ;
      ST_READ:  if (acc_zero) st_d = ST_IDLE;
      ST_WRITE: if (acc_zero) st_d = ST_WEND;
      ST_WEND:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '0;
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      st_q     <= st_d;
      done_q   <= empty_req || rd_end || (st_q == ST_WEND);
      rvalid_q <= rd_end;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
      end
      if (rd_end) rdata_q <= rd_masked;
    end
  end

  assign done       = done_q;
  assign rd_valid   = rvalid_q;
  assign rd_data    = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_ce_n   = !strobing;
  assign mem_we_n   = (st_q != ST_WRITE);
  assign mem_oe_n   = (st_q != ST_READ);
  assign mem_be_n   = lane_n;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (st_q == ST_WRITE) || (st_q == ST_WEND);
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              done,
  input logic              rd_valid,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [LANES-1:0]  be_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && we_n && oe_n && (&be_n) && !dq_oe)); // R1
  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !ce_n)); // R2
  AST_RVALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done); // R3
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R3
  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n && dq_oe)); // R4
  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe); // R5
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |=> !dq_oe); // R5
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe); // R6
  AST_TURN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !ready); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(addr)); // R10
endmodule

bind sram_byte_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .rd_valid(rd_valid),
  .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .be_n(mem_be_n),
  .dq_oe(mem_dq_oe), .addr(mem_addr)
);

// File: tb/tb_sram_byte_ctrl.sv
`timescale 1ns/1ps
module tb_sram_byte_ctrl;
  // Cycle counts restated by search: least n with n*5 >= t.
  function automatic int cyc(input int t);
    int n = 1;
    while (n * 5 < t) n++;
    return n;
  endfunction
  localparam int RD = cyc(55);
  localparam int WR = cyc(55);
  localparam int TN = cyc(20);

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0]  req_mask = 0;
  logic ready, done, rd_valid, ce_n, we_n, oe_n, dq_oe;
  logic [15:0] rd_data, dq_out, dq_in;
  logic [1:0]  be_n;
  logic [16:0] maddr;

  sram_byte_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .ready(ready), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(maddr), .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n),
    .mem_be_n(be_n), .mem_dq_out(dq_out), .mem_dq_oe(dq_oe), .mem_dq_in(dq_in)
  );

  // Memory model: disabled lanes return junk 8'hAA.
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  assign dq_in = (!ce_n && !oe_n) ?
      {be_n[1] ? 8'hAA : mem[maddr[7:0]][15:8], be_n[0] ? 8'hAA : mem[maddr[7:0]][7:0]}
      : 16'hDEAD;
  always @(posedge clk)
    if (!ce_n && !we_n) begin
      if (!be_n[0]) mem[maddr[7:0]][7:0]  <= dq_out[7:0];
      if (!be_n[1]) mem[maddr[7:0]][15:8] <= dq_out[15:8];
    end

  typedef struct {
    bit ce, we, oe; bit [1:0] be; bit dqoe, rdy, dn, rv;
    logic [15:0] data; logic [16:0] addr; int tag;
  } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0, cycles = 0;

  function automatic exp_t idle_e(bit rdy, int tag);
    exp_t e;
    e.ce = 1; e.we = 1; e.oe = 1; e.be = 2'b11; e.dqoe = 0; e.rdy = rdy;
    e.dn = 0; e.rv = 0; e.data = 0; e.addr = 0; e.tag = tag;
    return e;
  endfunction

  task automatic fail(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_fail++;
    $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
  endtask

  task automatic compare();
    exp_t e;
    e = (q.size() != 0) ? q.pop_front() : idle_e(1, 1); // R1 when nothing is pending
    n_run++;
    if ({ce_n, we_n, oe_n, be_n, dq_oe, ready, done, rd_valid} !==
        {e.ce, e.we, e.oe, e.be, e.dqoe, e.rdy, e.dn, e.rv})
      fail(e.tag, "strobes", {ce_n, we_n, oe_n, be_n, dq_oe, ready, done, rd_valid},
           {e.ce, e.we, e.oe, e.be, e.dqoe, e.rdy, e.dn, e.rv});
    if (!ce_n && maddr !== e.addr) fail(10, "address", maddr, e.addr); // R10
    if (dq_oe && e.dqoe && dq_out !== e.data) fail(e.tag, "write data", dq_out, e.data);
    if (rd_valid && e.rv) begin
      n_run++;
      if (rd_data !== e.data) fail(3, "read data", rd_data, e.data); // R3
    end
    if (dq_oe && !oe_n) fail(6, "bus fight", 1, 0); // R6
  endtask

  task automatic push(input bit w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    exp_t e;
    logic [15:0] r;
    if (m == 2'b00) begin                       // R8
      e = idle_e(1, 8); e.dn = 1; q.push_back(e);
    end else if (!w) begin                      // R2, R3, R7
      for (int i = 0; i < RD; i++) begin
        e = idle_e(0, 2); e.ce = 0; e.oe = 0; e.be = ~m; e.addr = a; q.push_back(e);
      end
      r = shadow[a[7:0]];
      e = idle_e(0, 3); e.dn = 1; e.rv = 1;
      e.data = {m[1] ? r[15:8] : 8'h00, m[0] ? r[7:0] : 8'h00};
      q.push_back(e);
      for (int i = 1; i < TN; i++) q.push_back(idle_e(0, 7));
    end else begin                              // R4, R5
      for (int i = 0; i < WR; i++) begin
        e = idle_e(0, 4); e.ce = 0; e.we = 0; e.be = ~m; e.dqoe = 1; e.data = d; e.addr = a;
        q.push_back(e);
      end
      e = idle_e(0, 5); e.dqoe = 1; e.data = d; q.push_back(e);
      e = idle_e(1, 5); e.dn = 1; q.push_back(e);
      if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
    end
  endtask

  task automatic tick(input bit v, input bit w, input logic [16:0] a,
                      input logic [15:0] d, input logic [1:0] m);
    @(negedge clk);
    compare();
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    if (v && ready) push(w, a, d, m);
  endtask

  // Holds a request until accepted, then lets the access run out.
  task automatic access(input bit w, input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
    while (!ready || q.size() > 1) tick(0, 0, 0, 0, 0);
    tick(1, w, a, d, m);
    tick(0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    while (q.size() != 0) tick(0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) tick(0, 0, 0, 0, 0);                 // R1 reset state
    access(1, 17'h00005, 16'h1234, 2'b11); drain(); // R4 R5 full write
    access(0, 17'h00005, 16'h0, 2'b11);    drain(); // R2 R3 full read
    access(1, 17'h00005, 16'hABCD, 2'b01); drain(); // R4 low lane only
    access(0, 17'h00005, 16'h0, 2'b11);    drain(); // R3 expects 12CD
    access(1, 17'h00006, 16'h77EE, 2'b10); drain(); // R4 high lane only
    access(0, 17'h00006, 16'h0, 2'b10);    drain(); // R3 low lane zeroed
    access(0, 17'h00007, 16'h0, 2'b01);    drain(); // R3 high lane zeroed
    access(1, 17'h00008, 16'hFFFF, 2'b00); drain(); // R8 empty write
    access(0, 17'h00008, 16'h0, 2'b00);    drain(); // R8 empty read
    access(0, 17'h00008, 16'h0, 2'b11);    drain(); // R8 memory untouched
    // R9: a write request held high while a read and its recovery run.
    while (!ready) tick(0, 0, 0, 0, 0);
    tick(1, 0, 17'h00009, 16'h0, 2'b11);
    for (int i = 0; i < RD + TN - 1; i++) tick(1, 1, 17'h00009, 16'hBEEF, 2'b11);
    tick(0, 0, 0, 0, 0);
    drain();
    access(0, 17'h00009, 16'h0, 2'b11);    drain(); // R9 location unchanged
    // R7: read directly followed by write; model expects ready low for TN cycles.
    access(0, 17'h0000A, 16'h0, 2'b11);
    access(1, 17'h0000A, 16'h5555, 2'b11); drain();
    access(1, 17'h1FFFF, 16'hC3A5, 2'b11); drain(); // R10 top address
    access(0, 17'h1FFFF, 16'h0, 2'b11);    drain(); // R10, R3
    access(1, 17'h00010, 16'h0F0F, 2'b00);          // R8 back to back
    access(1, 17'h00010, 16'h1111, 2'b11); drain();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule